// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns bytes written by a host into asynchronous serial frames on a single output line. Each frame has a low start bit and 5 to 8 data bits sent least significant bit first. An optional even or odd parity bit and one or two high stop bits follow. Every bit lasts sixteen pulses of an oversampling enable that a separate baud generator supplies. A two-entry queue sits in front of the shift register, so the host can stay ahead of the line.

A small command port controls the block. It can turn the transmitter on, turn it off, abort it at once, and start or end a break. A turned-off transmitter still finishes the character in flight and every queued character before it goes quiet. When clear-to-send gating is on, the active-low clear-to-send input is checked only at the moment a new character would start. Two status outputs report room in the queue and a fully drained transmitter.

Top module: `uart_tx_cts`

## Requirements
- R1: After the reset input, `txd` is high and both `tx_rdy` and `tx_emt` are low.
- R2: The enable command (`cmd_code` 1) sets `tx_emt` from the next cycle, and sets `tx_rdy` when the queue is not full.
- R3: `tx_rdy` is high exactly when the transmitter is enabled and the 2-entry queue is not full. With the shift register busy, two further queued characters drop `tx_rdy`.
- R4: An accepted write clears `tx_emt` on the next cycle. `tx_emt` becomes high again only when the queue is empty and the last stop bit has ended, or on an enable command.
- R5: Writes made while the transmitter is disabled or the queue is full are dropped. They produce no frame, and `tx_emt` does not change.
- R6: A frame is one low start bit, then `cfg_len`+5 data bits LSB first. If `cfg_par_en` is set, a parity bit follows that makes the count of ones even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1). Then come 1 stop bit, or 2 if `cfg_stop2` is set. Each bit lasts 16 `tick16` pulses, and `txd` stays high when idle.
- R7: The disable command (`cmd_code` 2) clears `tx_rdy`, but the character being sent and every queued character are still sent in full.
- R8: The abort command (`cmd_code` 3) drives `txd` high from the next cycle. It empties the queue, disables the transmitter and clears `tx_emt`, so nothing is sent until a new enable.
- R9: The break command (`cmd_code` 4) holds `txd` low from the next cycle until the break-end command (`cmd_code` 5) returns it high.
- R10: With `cts_en` high, a character starts only while `cts_n` is low. A rise of `cts_n` during a character does not disturb that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when high, even when low |
| cfg_stop2 | input | 1 | Two stop bits when high |
| cts_en | input | 1 | Clear-to-send gating on |
| cts_n | input | 1 | Clear-to-send, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 1 enable, 2 disable, 3 abort, 4 break, 5 break end |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| txd | output | 1 | Serial output |
| tx_rdy | output | 1 | Queue can take a character |
| tx_emt | output | 1 | Transmitter fully drained |

## Verification
The embedded assertions check several rules on every cycle. The queue never takes a push while full. An enable always leaves `tx_emt` high, an accepted write always clears it, and an abort always leaves the line high with both flags low. A break always pulls the line low, and no character starts while clear-to-send gating holds. Other behaviour only the bench scenarios can show: the bit-by-bit frame content for each length, parity and stop setting, the draining of the queue after a disable, flushed characters that never appear after an abort, and a character that finishes intact across a clear-to-send change.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      CMD_NOP     = 3'd0,
      CMD_ENABLE  = 3'd1,
      CMD_DISABLE = 3'd2,
      CMD_ABORT   = 3'd3,
      CMD_BRK_ON  = 3'd4,
      CMD_BRK_OFF = 3'd5
   } tx_cmd_e;

   typedef enum logic [2:0] {
      SH_IDLE,
      SH_START,
      SH_DATA,
      SH_PAR,
      SH_STOP
   } sh_state_e;

   typedef struct packed {
      logic [1:0] len;
      logic       par_en;
      logic       par_odd;
      logic       stop2;
   } frame_cfg_t;

endpackage

// File: rtl/tx_queue.sv
module tx_queue #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("tx_queue: DEPTH must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tx_queue: WIDTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic             vld;
         logic [WIDTH-1:0] hold;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld  <= 1'b0;
               hold <= '0;
            end else if (flush) begin
               vld <= 1'b0;
            end else if (push && !vld) begin
               vld  <= 1'b1;
               hold <= din;
            end else if (pop && vld) begin
               vld <= 1'b0;
            end
         end

         assign dout  = hold;
         assign empty = !vld;
         assign full  = vld;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);

         logic [WIDTH-1:0] mem [DEPTH];
         logic [PW-1:0]    wp, rp;
         logic [CW-1:0]    cnt;
         logic             do_push, do_pop;

         assign do_push = push && (cnt != CW'(DEPTH));
         assign do_pop  = pop && (cnt != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else if (flush) begin
               wp  <= '0;
               rp  <= '0;
               cnt <= '0;
            end else begin
               if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
               if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
               if (do_push && !do_pop)      cnt <= cnt + 1'b1;
               else if (do_pop && !do_push) cnt <= cnt - 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (do_push && !flush) mem[wp] <= din;
         end

         assign dout  = mem[rp];
         assign empty = (cnt == '0);
         assign full  = (cnt == CW'(DEPTH));
      end
   endgenerate

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full)
      else $error("R3: push into full queue");

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
   import uart_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              tick,
   input  frame_cfg_t        cfg,
   input  logic              cts_en,
   input  logic              cts_n,
   input  logic              hold,
   input  logic              avail,
   input  logic [DATA_W-1:0] data,
   output logic              take,
   output logic              busy,
   output logic              done,
   output logic              txd_bit
);

   localparam int TW       = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam int BW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int MIN_BITS = DATA_W - 3;

   generate
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("tx_shifter: OVERSAMPLE must be at least 2");
      end
      if (DATA_W < 4) begin : g_bad_w
         $error("tx_shifter: DATA_W must be at least 4");
      end
   endgenerate

   sh_state_e         state;
   logic [TW-1:0]     tcnt;
   logic [BW-1:0]     bidx;
   logic              sidx;
   logic [DATA_W-1:0] sh;
   logic              par_q;
   frame_cfg_t        cfg_q;
   logic              txq;
   logic              done_q;

   logic [DATA_W-1:0] mask;
   logic              load_par;
   logic [BW-1:0]     last_idx;
   logic              bit_end;
   logic              cts_ok;

   assign mask     = {DATA_W{1'b1}} >> (2'd3 - cfg.len);
   assign load_par = cfg.par_odd ^ (^(data & mask));
   assign last_idx = BW'(MIN_BITS - 1) + BW'(cfg_q.len);
   assign bit_end  = tick && (tcnt == TW'(OVERSAMPLE - 1));
   assign cts_ok   = !cts_en || !cts_n;

   assign take    = (state == SH_IDLE) && avail && !hold && !abort && cts_ok;
   assign busy    = (state != SH_IDLE);
   assign done    = done_q;
   assign txd_bit = txq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SH_IDLE;
         tcnt   <= '0;
         bidx   <= '0;
         sidx   <= 1'b0;
         sh     <= '0;
         par_q  <= 1'b0;
         cfg_q  <= '0;
         txq    <= 1'b1;
         done_q <= 1'b0;
      end else if (abort) begin
         state  <= SH_IDLE;
         tcnt   <= '0;
         txq    <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state == SH_IDLE) begin
            if (take) begin
               state <= SH_START;
               txq   <= 1'b0;
               sh    <= data & mask;
               par_q <= load_par;
               cfg_q <= cfg;
               tcnt  <= '0;
               bidx  <= '0;
               sidx  <= 1'b0;
            end
         end else if (tick) begin
            if (!bit_end) begin
               tcnt <= tcnt + 1'b1;
            end else begin
               tcnt <= '0;
               unique case (state)
                  SH_START: begin
                     state <= SH_DATA;
                     txq   <= sh[0];
                  end
                  SH_DATA: begin
                     if (bidx == last_idx) begin
                        if (cfg_q.par_en) begin
                           state <= SH_PAR;
                           txq   <= par_q;
                        end else begin
                           state <= SH_STOP;
                           txq   <= 1'b1;
                        end
                     end else begin
                        bidx <= bidx + 1'b1;
                        sh   <= sh >> 1;
                        txq  <= sh[1];
                     end
                  end
                  SH_PAR: begin
                     state <= SH_STOP;
                     txq   <= 1'b1;
                  end
                  SH_STOP: begin
                     if (sidx == cfg_q.stop2) begin
                        state  <= SH_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        sidx <= 1'b1;
                     end
                  end
                  default: state <= SH_IDLE;
               endcase
            end
         end
      end
   end

   // R10: a character never begins while gating is on and clear-to-send is inactive
   a_r10_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(cts_en)) |-> !$past(cts_n))
      else $error("R10: character started with cts_n high");

   // R6: leaving idle always begins with a low start bit
   a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd_bit)
      else $error("R6: frame start not low");

endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
   import uart_tx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 2,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_stop2,
   input  logic              cts_en,
   input  logic              cts_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_code,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              tx_rdy,
   output logic              tx_emt
);

   tx_cmd_e     cmd;
   logic        is_en, is_dis, is_abort, is_brk_on, is_brk_off;
   logic        enabled, brk, emt_q;
   logic        accept;
   logic        q_empty, q_full, q_pop;
   logic [DATA_W-1:0] q_dout;
   logic        sh_busy, sh_done, sh_txd;
   frame_cfg_t  cfg;

   assign cmd        = tx_cmd_e'(cmd_code);
   assign is_en      = cmd_valid && (cmd == CMD_ENABLE);
   assign is_dis     = cmd_valid && (cmd == CMD_DISABLE);
   assign is_abort   = cmd_valid && (cmd == CMD_ABORT);
   assign is_brk_on  = cmd_valid && (cmd == CMD_BRK_ON);
   assign is_brk_off = cmd_valid && (cmd == CMD_BRK_OFF);

   assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

   assign accept = wr_en && enabled && !q_full && !is_abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled <= 1'b0;
         brk     <= 1'b0;
         emt_q   <= 1'b0;
      end else if (is_abort) begin
         enabled <= 1'b0;
         brk     <= 1'b0;
         emt_q   <= 1'b0;
      end else begin
         if (is_en)       enabled <= 1'b1;
         else if (is_dis) enabled <= 1'b0;

         if (is_brk_on)       brk <= 1'b1;
         else if (is_brk_off) brk <= 1'b0;

         if (is_en)                  emt_q <= 1'b1;
         else if (accept)            emt_q <= 1'b0;
         else if (sh_done && q_empty) emt_q <= 1'b1;
      end
   end

   tx_queue #(
      .WIDTH (DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (is_abort),
      .push  (accept),
      .din   (wr_data),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   tx_shifter #(
      .DATA_W     (DATA_W),
      .OVERSAMPLE (OVERSAMPLE)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort   (is_abort),
      .tick    (tick16),
      .cfg     (cfg),
      .cts_en  (cts_en),
      .cts_n   (cts_n),
      .hold    (brk),
      .avail   (!q_empty),
      .data    (q_dout),
      .take    (q_pop),
      .busy    (sh_busy),
      .done    (sh_done),
      .txd_bit (sh_txd)
   );

   assign txd    = brk ? 1'b0 : sh_txd;
   assign tx_rdy = enabled && !q_full;
   assign tx_emt = emt_q;

   a_r2_enable_sets_emt: assert property (@(posedge clk) disable iff (!rst_n)
      is_en |=> tx_emt)
      else $error("R2: enable did not set tx_emt");

   a_r4_write_clears_emt: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !is_en) |=> !tx_emt)
      else $error("R4: accepted write left tx_emt set");

   a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      is_abort |=> (txd && !tx_rdy && !tx_emt && !sh_busy))
      else $error("R8: abort did not idle the transmitter");

   a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      (is_brk_on && !is_abort) |=> !txd)
      else $error("R9: break did not pull txd low");

   a_r5_drop_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tx_rdy && !cmd_valid && !sh_done) |=> $stable(tx_emt))
      else $error("R5: dropped write changed tx_emt");

endmodule

// File: tb/tb_uart_tx_cts.sv
`timescale 1ns/1ps
module tb_uart_tx_cts;

   localparam int BIT_CYC  = 64;   // 16 ticks x 4 cycles
   localparam int HALF_CYC = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
   logic       cts_en = 1'b0, cts_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       txd, tx_rdy, tx_emt;

   int checks = 0, errors = 0;
   bit mon_off = 1'b0;
   bit finished = 1'b0;
   logic [7:0] rx_q [$];
   bit         ok_q [$];

   always #5 clk = ~clk;

   uart_tx_cts dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop2(cfg_stop2), .cts_en(cts_en), .cts_n(cts_n),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .wr_en(wr_en), .wr_data(wr_data),
      .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
   );

   initial begin
      int c;
      c = 0;
      forever begin
         @(negedge clk);
         tick16 = (c == 3);
         c = (c == 3) ? 0 : c + 1;
      end
   end

   function automatic logic exp_par(input logic [7:0] d, input int nb, input logic odd);
      logic p;
      p = odd;
      for (int i = 0; i < nb; i++) p ^= d[i];
      return p;
   endfunction

   function automatic logic [7:0] trim(input logic [7:0] d, input logic [1:0] len);
      return d & (8'hFF >> (3 - len));
   endfunction

   // frame decoder
   initial begin
      forever begin
         @(negedge clk);
         if (!mon_off && rst_n && txd === 1'b0) begin
            int nb;
            logic pe, po, s2, st, p, stp;
            logic [7:0] d;
            nb = cfg_len + 5; pe = cfg_par_en; po = cfg_par_odd; s2 = cfg_stop2;
            d = 8'h00; p = 1'b0; stp = 1'b1;
            repeat (HALF_CYC) @(negedge clk);
            st = txd;
            for (int i = 0; i < nb; i++) begin
               repeat (BIT_CYC) @(negedge clk);
               d[i] = txd;
            end
            if (pe) begin
               repeat (BIT_CYC) @(negedge clk);
               p = txd;
            end
            for (int s = 0; s <= int'(s2); s++) begin
               repeat (BIT_CYC) @(negedge clk);
               stp &= txd;
            end
            rx_q.push_back(d);
            ok_q.push_back((st == 1'b0) && stp && (!pe || p == exp_par(d, nb, po)));
         end
      end
   end

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_cmd(input logic [2:0] c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = 3'd0;
   endtask

   task automatic write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_rx(input int n);
      int t;
      t = 0;
      while (rx_q.size() < n && t < 20000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic clear_rx();
      rx_q.delete();
      ok_q.delete();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      logic [7:0] exp_d [$];
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1 && tx_rdy == 1'b0 && tx_emt == 1'b0, "R1 reset state",
          {txd, tx_rdy, tx_emt}, 3'b100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 write while disabled ignored
      write(8'h5A);
      repeat (900) @(negedge clk);
      chk(rx_q.size() == 0 && txd == 1'b1 && tx_emt == 1'b0, "R5 write while disabled",
          rx_q.size(), 0);

      // R2 enable
      send_cmd(3'd1);
      chk(tx_rdy == 1'b1 && tx_emt == 1'b1, "R2 enable sets flags", {tx_rdy, tx_emt}, 2'b11);

      // R4 / R6 one 8N1 char
      clear_rx();
      write(8'hA5);
      chk(tx_emt == 1'b0, "R4 write clears tx_emt", tx_emt, 0);
      wait_rx(1);
      chk(rx_q.size() == 1 && rx_q[0] == 8'hA5 && ok_q[0], "R6 8N1 frame",
          rx_q.size() ? rx_q[0] : 0, 8'hA5);
      repeat (BIT_CYC) @(negedge clk);
      chk(tx_emt == 1'b1, "R4 tx_emt after last stop", tx_emt, 1);

      // R3 queue fills, R5 overflow dropped, R7 disable drains
      clear_rx();
      write(8'h11); write(8'h22); write(8'h33);
      chk(tx_rdy == 1'b0, "R3 tx_rdy low when queue full", tx_rdy, 0);
      write(8'h44);
      send_cmd(3'd2);
      chk(tx_rdy == 1'b0, "R7 disable clears tx_rdy", tx_rdy, 0);
      wait_rx(3);
      repeat (1200) @(negedge clk);
      chk(rx_q.size() == 3, "R7 queued chars drained after disable", rx_q.size(), 3);
      if (rx_q.size() == 3)
         chk(rx_q[0] == 8'h11 && rx_q[1] == 8'h22 && rx_q[2] == 8'h33 && ok_q[0] && ok_q[1] && ok_q[2],
             "R7 drained data order", {rx_q[0], rx_q[1], rx_q[2]}, 24'h112233);
      chk(tx_emt == 1'b1, "R4 tx_emt after drain", tx_emt, 1);

      // R9 break
      send_cmd(3'd1);
      mon_off = 1'b1;
      send_cmd(3'd4);
      chk(txd == 1'b0, "R9 break drives low", txd, 0);
      repeat (300) @(negedge clk);
      chk(txd == 1'b0, "R9 break held", txd, 0);
      send_cmd(3'd5);
      chk(txd == 1'b1, "R9 break end restores high", txd, 1);
      repeat (4) @(negedge clk);
      mon_off = 1'b0;

      // R10 CTS gating
      clear_rx();
      cts_en = 1'b1; cts_n = 1'b1;
      write(8'h3C);
      repeat (1500) @(negedge clk);
      chk(rx_q.size() == 0 && txd == 1'b1, "R10 held while cts_n high", rx_q.size(), 0);
      cts_n = 1'b0;
      repeat (200) @(negedge clk);
      cts_n = 1'b1;
      wait_rx(1);
      chk(rx_q.size() == 1 && rx_q[0] == 8'h3C && ok_q[0], "R10 char intact across cts rise",
          rx_q.size() ? rx_q[0] : 0, 8'h3C);
      cts_en = 1'b0; cts_n = 1'b0;
      repeat (BIT_CYC) @(negedge clk);

      // R8 abort mid-character
      write(8'h00); write(8'h0F);
      repeat (300) @(negedge clk);
      mon_off = 1'b1;
      send_cmd(3'd3);
      chk(txd == 1'b1 && tx_rdy == 1'b0 && tx_emt == 1'b0, "R8 abort idles at once",
          {txd, tx_rdy, tx_emt}, 3'b100);
      begin
         bit all_high;
         all_high = 1'b1;
         for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            all_high &= txd;
         end
         chk(all_high, "R8 line stays high after abort", all_high, 1);
      end
      clear_rx();
      mon_off = 1'b0;
      send_cmd(3'd1);
      repeat (1500) @(negedge clk);
      chk(rx_q.size() == 0, "R8 queue flushed by abort", rx_q.size(), 0);

      // R6 / R3 randomized frames
      for (int it = 0; it < 10; it++) begin
         int n;
         cfg_len = 2'($urandom_range(0, 3));
         cfg_par_en = 1'($urandom_range(0, 1));
         cfg_par_odd = 1'($urandom_range(0, 1));
         cfg_stop2 = 1'($urandom_range(0, 1));
         n = $urandom_range(1, 3);
         clear_rx();
         exp_d.delete();
         for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            exp_d.push_back(trim(d, cfg_len));
            write(d);
         end
         chk(tx_rdy == (n < 3), "R3 tx_rdy versus queue fill", tx_rdy, (n < 3));
         wait_rx(n);
         repeat (BIT_CYC) @(negedge clk);
         chk(rx_q.size() == n, "R6 random frame count", rx_q.size(), n);
         for (int k = 0; k < n && k < rx_q.size(); k++)
            chk(rx_q[k] == exp_d[k] && ok_q[k], "R6 random frame content", rx_q[k], exp_d[k]);
         chk(tx_emt == 1'b1, "R4 tx_emt after random burst", tx_emt, 1);
      end

      finish_run();
   end

endmodule